// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers up to 32 peripheral interrupt request lines into one cascaded request to a host processor. Each source is latched as pending when it raises a request. A source competes only while its mask bit is set. A fixed priority order picks one winner among the competing sources. The order can be changed in two ways. Four serial-channel sources can be placed into four grouped priority slots, and any single source can be raised above all the others.

The host works through a small register port with four word registers: configuration, mask, in-service and vector. To take an interrupt, the host writes the acknowledge bit of the vector register and then reads that register to get the number of the winning source. That source becomes in service and its pending bit is cleared. Lower-priority work stays held off until the host ends service by writing a one to the source's in-service bit. Vector 0 is never a real source. The acknowledge returns it when no valid source remains, which happens when a source was masked between raising the request and the acknowledge.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the configuration, mask, in-service and vector registers all read 0, and `hostIrq` is low.
- R2: Mask register (address 1) bit v enables source v when it is 1. A pending source whose mask bit is 0 never raises `hostIrq` and is never chosen by an acknowledge, but it stays pending.
- R3: `hostIrq` is driven only while the global enable bit (configuration bit 16) is 1. Clearing that bit drops the request on the next cycle.
- R4: With no slot or raise setting affecting them, a source with a higher number has priority over one with a lower number.
- R5: Serial channel c (c = 0..3) is source 30-c. Configuration bits [7:0] hold four 2-bit channel numbers for slots A (bits 1:0), B (3:2), C (5:4) and D (7:6). A channel named by a slot takes that slot's rank, with A above B above C above D, and all slots rank above the ordinary sources. When a channel is named by more than one slot, the first slot that names it applies.
- R6: A nonzero source number in configuration bits [12:8] raises that source above every other source. A value of 0 raises nothing.
- R7: Writing 1 to bit 0 of the vector register (address 3) is an acknowledge. On the next cycle, bits [15:11] of that register read the winner's number, the winner's in-service bit is 1, and its pending bit is cleared. The acknowledge chooses among sources ranked above every in-service source, whatever the global enable is.
- R8: `hostIrq` is high only when a pending, unmasked source ranks above every source that is in service. A source of lower rank waits until the in-service bits above it are cleared.
- R9: Writing to the in-service register (address 2) clears each bit written as 1 and leaves each bit written as 0 unchanged. The in-service register changes only through such writes and through acknowledges.
- R10: An acknowledge with no eligible source loads vector 0 and leaves the in-service register unchanged.
- R11: `hostLevel` always equals configuration bits [15:13].
- R12: Request line 0 is ignored. Vector 0 never becomes pending or in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcReq | input | 32 | Peripheral request lines, one per vector |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 configuration, 1 mask, 2 in-service, 3 vector |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr`, combinational |
| hostIrq | output | 1 | Cascaded request to the host |
| hostLevel | output | 3 | Host interrupt level taken from the configuration |

## Verification
A request sampled on a rising edge becomes pending on that edge, so it can affect `hostIrq` from the following cycle. A register write takes effect on the edge that samples it. This means `hostIrq`, `hostLevel` and the read data reflect the write one cycle later. An acknowledge written in one cycle is read back as a vector in the next. The bench drives inputs on the falling edge and compares `hostIrq` and `hostLevel` on every falling edge against a behavioural model that is updated on the same rising edges as the design. Register reads are sampled a short delay after the address changes, so that every comparison falls inside the cycle in which the result is due.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW   = 2;
  localparam int SLOTS    = 4;
  localparam int SLOT_W   = 2;
  localparam int SLOT_LSB = 0;
  localparam int HI_LSB   = 8;
  localparam int VEC_LSB  = 11;
  localparam int LVL_LSB  = 13;
  localparam int LVL_W    = 3;
  localparam int EN_BIT   = 16;
  localparam int ACK_BIT  = 0;
  localparam int CHAN_TOP = 30;

  typedef enum logic [REG_AW-1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_SERV = 2'd2,
    ADDR_VEC  = 2'd3
  } regAddrE;

  typedef struct packed {
    logic cfgWr;
    logic maskWr;
    logic servClr;
    logic ack;
  } strobeT;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              regWr,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              ackBit,
  output strobeT            strobe,
  output regAddrE           rdSel
);
  always_comb begin
    rdSel  = regAddrE'(regAddr);
    strobe = '0;
    if (regWr) begin
      unique case (rdSel)
        ADDR_CFG:  strobe.cfgWr   = 1'b1;
        ADDR_MASK: strobe.maskWr  = 1'b1;
        ADDR_SERV: strobe.servClr = 1'b1;
        ADDR_VEC:  strobe.ack     = ackBit;
        default:   strobe         = '0;
      endcase
    end
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  strobeT             strobe,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  cfgQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [NUM_SRC-1:0] servQ,
  output logic [VEC_W-1:0]   vecQ,
  output logic               irqReq
);
  localparam int KEY_W = $clog2(NUM_SRC + SLOTS + 2);
  localparam logic [KEY_W-1:0] KEY_NONE = '1;

  logic [NUM_SRC-1:0] pendQ;
  logic [KEY_W-1:0]   keyArr [NUM_SRC];
  logic [KEY_W-1:0]   candKey, servKey;
  logic [VEC_W-1:0]   candVec;
  logic               win;
  logic [NUM_SRC-1:0] winOh;

  // Rank key: smaller is more urgent. 0 = raised source, 1..SLOTS = grouped
  // slot A..D, above that the plain descending-number order.
  function automatic logic [KEY_W-1:0] prioKey(input int v, input logic [DATA_W-1:0] cfg);
    logic [KEY_W-1:0] k;
    logic hit;
    k   = KEY_W'(SLOTS + 1 + (NUM_SRC - 1 - v));
    hit = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (!hit && v == CHAN_TOP - int'(cfg[SLOT_LSB + s*SLOT_W +: SLOT_W])) begin
        k   = KEY_W'(s + 1);
        hit = 1'b1;
      end
    end
    if (cfg[HI_LSB +: VEC_W] != '0 && v == int'(cfg[HI_LSB +: VEC_W])) k = '0;
    return k;
  endfunction

  for (genvar v = 0; v < NUM_SRC; v++) begin : gKey
    assign keyArr[v] = prioKey(v, cfgQ);
  end

  always_comb begin
    candKey = KEY_NONE;
    servKey = KEY_NONE;
    candVec = '0;
    for (int v = 1; v < NUM_SRC; v++) begin
      if (pendQ[v] && maskQ[v] && keyArr[v] < candKey) begin
        candKey = keyArr[v];
        candVec = VEC_W'(v);
      end
      if (servQ[v] && keyArr[v] < servKey) servKey = keyArr[v];
    end
    win   = candKey < servKey;
    winOh = win ? (NUM_SRC'(1) << candVec) : '0;
  end

  assign irqReq = cfgQ[EN_BIT] && win;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      maskQ <= '0;
      servQ <= '0;
      pendQ <= '0;
      vecQ  <= '0;
    end else begin
      pendQ <= (pendQ & ~(strobe.ack ? winOh : '0)) | (srcReq & ~NUM_SRC'(1));
      if (strobe.cfgWr)  cfgQ  <= wrData;
      if (strobe.maskWr) maskQ <= wrData[NUM_SRC-1:0];
      if (strobe.servClr) servQ <= servQ & ~wrData[NUM_SRC-1:0];
      else if (strobe.ack) servQ <= servQ | winOh;
      if (strobe.ack) vecQ <= win ? candVec : '0;
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic               regWr,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               hostIrq,
  output logic [LVL_W-1:0]   hostLevel
);
  localparam int VEC_W = $clog2(NUM_SRC);

  strobeT             strobe;
  regAddrE            rdSel;
  logic [DATA_W-1:0]  cfgQ;
  logic [NUM_SRC-1:0] maskQ, servQ;
  logic [VEC_W-1:0]   vecQ;

  vic_ctrl uCtrl (
    .regWr  (regWr),
    .regAddr(regAddr),
    .ackBit (regWrData[ACK_BIT]),
    .strobe (strobe),
    .rdSel  (rdSel)
  );

  vic_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .srcReq(srcReq),
    .strobe(strobe),
    .wrData(regWrData),
    .cfgQ  (cfgQ),
    .maskQ (maskQ),
    .servQ (servQ),
    .vecQ  (vecQ),
    .irqReq(hostIrq)
  );

  assign hostLevel = cfgQ[LVL_LSB +: LVL_W];

  always_comb begin
    regRdData = '0;
    unique case (rdSel)
      ADDR_CFG:  regRdData = cfgQ;
      ADDR_MASK: regRdData = DATA_W'(maskQ);
      ADDR_SERV: regRdData = DATA_W'(servQ);
      ADDR_VEC:  regRdData[VEC_LSB +: VEC_W] = vecQ;
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/vic_checker.sv
module vic_checker
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  localparam int VEC_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [REG_AW-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWrData,
  input logic               hostIrq,
  input logic [DATA_W-1:0]  cfgQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [NUM_SRC-1:0] servQ,
  input logic [VEC_W-1:0]   vecQ
);
  logic ackNow;
  assign ackNow = regWr && regAddr == ADDR_VEC && regWrData[ACK_BIT];

  assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> cfgQ[EN_BIT]);

  assert_mask_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_MASK) |=> maskQ == $past(regWrData[NUM_SRC-1:0]));

  assert_serv_w1c_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr == ADDR_SERV) |=> servQ == ($past(servQ) & ~$past(regWrData[NUM_SRC-1:0])));

  assert_serv_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !regWr |=> $stable(servQ));

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    ackNow |=> ($countones(servQ & ~$past(servQ)) <= 1) && (vecQ == '0 || servQ[vecQ]));

  assert_err_keeps_serv_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackNow |=> (vecQ != '0) || (servQ == $past(servQ)));

  assert_vec0_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    !servQ[0]);
endmodule

bind vec_irq_ctrl vic_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .regWr    (regWr),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .hostIrq  (hostIrq),
  .cfgQ     (cfgQ),
  .maskQ    (maskQ),
  .servQ    (servQ),
  .vecQ     (vecQ)
);

// File: tb/sim_vec_irq_ctrl.sv
`timescale 1ns/1ps
module sim_vec_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcReq = '0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        hostIrq;
  logic [2:0]  hostLevel;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  localparam logic [31:0] EN = 32'h1 << 16;

  always #2.5 clk = ~clk;

  vec_irq_ctrl u0 (.clk(clk), .rstN(rstN), .srcReq(srcReq), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .hostIrq(hostIrq), .hostLevel(hostLevel));

  // Behavioural reference model
  bit [31:0] mCfg, mMask, mServ, mPend;
  int mVec, mW;

  function automatic int mWinner();
    int order[$];
    int hi;
    hi = int'(mCfg[12:8]);
    if (hi != 0) order.push_back(hi);
    for (int s = 0; s < 4; s++) begin
      int v;
      v = 30 - int'((mCfg >> (2*s)) & 32'h3);
      if (!(v inside {order})) order.push_back(v);
    end
    for (int v = 31; v >= 1; v--)
      if (!(v inside {order})) order.push_back(v);
    foreach (order[i]) begin
      if (mServ[order[i]]) return 0;
      if (mPend[order[i]] && mMask[order[i]]) return order[i];
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCfg = 0; mMask = 0; mServ = 0; mPend = 0; mVec = 0;
    end else begin
      mW = mWinner();
      if (regWr) begin
        case (regAddr)
          2'd0: mCfg = regWrData;
          2'd1: mMask = regWrData;
          2'd2: mServ = mServ & ~regWrData;
          default: if (regWrData[0]) begin
            mVec = mW;
            if (mW != 0) begin mServ[mW] = 1'b1; mPend[mW] = 1'b0; end
          end
        endcase
      end
      mPend = mPend | (srcReq & ~32'h1);
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check(hostIrq == (mCfg[16] && mWinner() != 0), {curReq, " hostIrq"}, hostIrq, mCfg[16] && mWinner() != 0);
      check(hostLevel == mCfg[15:13], "R11 hostLevel", hostLevel, mCfg[15:13]);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [31:0] s);
    @(negedge clk); srcReq = s;
    @(negedge clk); srcReq = '0;
  endtask

  task automatic rdChk(input logic [1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData == exp, req, regRdData, exp);
  endtask

  task automatic ackExp(input int v, input string req);
    wr(2'd3, 32'h1);
    rdChk(2'd3, 32'(v) << 11, req);
  endtask

  task automatic irqChk(input bit exp, input string req);
    @(negedge clk); #1;
    check(hostIrq == exp, req, hostIrq, exp);
  endtask

  task automatic finishRun();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    rdChk(2'd0, 0, "R1 cfg");
    rdChk(2'd1, 0, "R1 mask");
    rdChk(2'd2, 0, "R1 serv");
    rdChk(2'd3, 0, "R1 vec");
    irqChk(0, "R1 irq");

    curReq = "R2";
    wr(2'd0, 32'd5 << 13);
    @(negedge clk); check(hostLevel == 3'd5, "R11 level", hostLevel, 5);
    pulse(32'h1 << 5);
    irqChk(0, "R3 disabled");
    wr(2'd0, (32'd5 << 13) | EN);
    irqChk(0, "R2 masked");
    wr(2'd1, 32'h1 << 5);
    irqChk(1, "R2 unmasked");
    curReq = "R3";
    wr(2'd0, 32'd5 << 13);
    irqChk(0, "R3 enable off");
    wr(2'd0, EN);
    irqChk(1, "R3 enable on");
    curReq = "R7";
    ackExp(5, "R7 vector");
    rdChk(2'd2, 32'h1 << 5, "R7 serv");
    irqChk(0, "R7 pending cleared");
    wr(2'd2, 32'h1 << 5);
    rdChk(2'd2, 0, "R9 clear");

    curReq = "R4";
    wr(2'd1, 32'hFFFF_FFFF);
    pulse((32'h1 << 3) | (32'h1 << 9) | (32'h1 << 20));
    ackExp(20, "R4 highest number");
    curReq = "R8";
    irqChk(0, "R8 lower blocked");
    pulse(32'h1 << 25);
    irqChk(1, "R8 preempt");
    ackExp(25, "R8 nested vector");
    rdChk(2'd2, (32'h1 << 20) | (32'h1 << 25), "R7 two in service");
    curReq = "R9";
    wr(2'd2, 32'h0);
    rdChk(2'd2, (32'h1 << 20) | (32'h1 << 25), "R9 zero write");
    wr(2'd2, 32'h1 << 25);
    rdChk(2'd2, 32'h1 << 20, "R9 single clear");
    irqChk(0, "R8 still blocked");
    wr(2'd2, 32'h1 << 20);
    irqChk(1, "R8 released");
    ackExp(9, "R4 next");
    wr(2'd2, 32'hFFFF_FFFF);
    ackExp(3, "R4 last");
    wr(2'd2, 32'hFFFF_FFFF);

    curReq = "R5";
    wr(2'd0, EN | 32'h72);
    pulse((32'h1 << 31) | (32'h1 << 30) | (32'h1 << 28) | (32'h1 << 27));
    ackExp(28, "R5 slot A");
    wr(2'd2, 32'hFFFF_FFFF);
    ackExp(30, "R5 slot B");
    wr(2'd2, 32'hFFFF_FFFF);
    ackExp(27, "R5 slot C");
    wr(2'd2, 32'hFFFF_FFFF);
    ackExp(31, "R5 ordinary below slots");
    wr(2'd2, 32'hFFFF_FFFF);

    curReq = "R6";
    wr(2'd0, EN | 32'h72 | (32'd4 << 8));
    pulse((32'h1 << 4) | (32'h1 << 28));
    ackExp(4, "R6 raised source");
    irqChk(0, "R6 raised blocks slot A");
    wr(2'd2, 32'hFFFF_FFFF);
    ackExp(28, "R6 then slot");
    wr(2'd2, 32'hFFFF_FFFF);

    curReq = "R10";
    wr(2'd0, EN);
    pulse(32'h1 << 7);
    irqChk(1, "R10 raised");
    wr(2'd1, ~(32'h1 << 7));
    irqChk(0, "R10 masked");
    ackExp(0, "R10 error vector");
    rdChk(2'd2, 0, "R10 serv kept");
    wr(2'd1, 32'hFFFF_FFFF);
    irqChk(1, "R2 still pending");
    ackExp(7, "R2 later served");
    wr(2'd2, 32'hFFFF_FFFF);

    curReq = "R12";
    pulse(32'h1);
    irqChk(0, "R12 line 0");
    ackExp(0, "R12 vector 0");
    rdChk(2'd2, 0, "R12 serv");

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule